// File: doc/BRIEF.md
# Oversampled UART Transmit Engine

This block turns bytes held in an external transmit queue into asynchronous serial frames. Each frame opens with a low start bit. The configured number of data bits follows, least significant bit first, then an optional parity bit and one or two high stop bits. The engine times every bit from a one-cycle enable pulse that runs at sixteen times the baud rate, so the baud generator stays outside the block. The queue itself is also external: the engine reads its head entry directly and pulses a pop strobe in the cycle it takes that entry.

Frames follow one another without idle time for as long as the queue has entries and transmission is enabled. The line settings are captured when each frame starts and apply to the whole of that frame. A status output reports activity. It rises as soon as the queue is non-empty and falls only once the queue is drained and the final stop bit has left the line. It does this whether or not transmission is currently enabled, so software can use it to learn when the line has truly gone quiet.

Top module: `uart_tx_engine`

## Requirements
- R1: After reset and with an empty queue, `txd_o` is 1, `busy_o` is 0 and `fifo_pop_o` is 0; whenever `busy_o` is 0 the line is high.
- R2: A frame is a 0 start bit, then N data bits LSB first, then stop bits at 1. N is 5 + `word_len_i` (0→5, 1→6, 2→7, 3→8); only the low N bits of the byte are sent.
- R3: Every bit of a frame, start and stop bits included, lasts exactly 16 clock cycles in which `tick16_i` is 1. Cycles without a tick do not advance the frame, and the line changes only on a tick or on a frame load.
- R4: With `parity_en_i`=1, one parity bit follows the data bits. It covers the N data bits only. `parity_odd_i`=0 selects even parity (data plus parity bit hold an even number of ones) and 1 selects odd parity.
- R5: `two_stop_i`=0 gives one stop bit and `two_stop_i`=1 gives two.
- R6: A frame starts only while `tx_en_i`=1 and `fifo_empty_i`=0. At that point `fifo_pop_o` is 1 for exactly one cycle and `fifo_data_i` is taken as the frame's byte. The start bit appears on the line in the next cycle.
- R7: If the queue still holds data and the engine is enabled when the last stop bit ends, the next start bit begins in the very next cycle, with no idle time between frames.
- R8: `busy_o` is 1 whenever the queue is non-empty or a frame is in progress, regardless of `tx_en_i`. It is 0 only when the queue is empty and the last stop bit has finished.
- R9: Dropping `tx_en_i` during a frame does not cut that frame short. No further frame starts while `tx_en_i` is 0.
- R10: Word length, parity and stop settings are captured at frame start. Changing them during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick16_i | input | 1 | Oversampling enable, one pulse per 1/16 bit |
| tx_en_i | input | 1 | Allows new frames to start |
| word_len_i | input | 2 | Data bit count minus 5 |
| parity_en_i | input | 1 | Adds a parity bit |
| parity_odd_i | input | 1 | 1 = odd parity, 0 = even |
| two_stop_i | input | 1 | 1 = two stop bits |
| fifo_empty_i | input | 1 | Transmit queue is empty |
| fifo_data_i | input | 8 | Head entry of the transmit queue |
| fifo_pop_o | output | 1 | Removes the head entry |
| txd_o | output | 1 | Serial line, idles high |
| busy_o | output | 1 | Queue non-empty or frame in progress |

## Verification
The vector table sends single frames over all four word lengths, with no, even and odd parity, one and two stop bits, and tick enables arriving every cycle or every second, third or fourth cycle. Each bit is sampled one tick after its start, at its middle and one tick before its end. An error in bit length, data order, parity polarity, parity coverage or stop count shows up as a sample mismatch. A burst of three queued bytes separates gapless frame chaining from a design that returns to idle between frames. Separate cases drop the enable, or flip every line setting, partway through a frame, and hold data in the queue while the engine is disabled. These show that a running frame is never truncated or reshaped, and that the status output follows the queue rather than the enable.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

   // Position within a frame
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_START,
      PH_DATA,
      PH_PARITY,
      PH_STOP
   } tx_phase_e;

   // Framing options captured at frame start
   typedef struct packed {
      logic par_en;
      logic par_odd;
      logic stop2;
   } frame_opts_t;

endpackage

// File: rtl/uart_tx_bit_timer.sv
// Counts oversampling ticks and flags the last tick of each bit.
module uart_tx_bit_timer #(
   parameter int unsigned OVERSAMPLE = 16
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic restart_i,
   input  logic run_i,
   input  logic tick_i,
   output logic bit_done_o
);

   localparam int unsigned CNT_W = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(OVERSAMPLE - 1);
   localparam bit POW2 = ((2 ** CNT_W) == OVERSAMPLE);

   logic [CNT_W-1:0] cnt_q;
   logic             at_last;

   assign at_last    = (cnt_q == LAST);
   assign bit_done_o = run_i && tick_i && at_last;

   generate
      if (POW2) begin : g_wrap
         // counter range matches the ratio exactly: natural wrap
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)                cnt_q <= '0;
            else if (restart_i)         cnt_q <= '0;
            else if (run_i && tick_i)   cnt_q <= cnt_q + 1'b1;
         end
      end else begin : g_cmp
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)                cnt_q <= '0;
            else if (restart_i)         cnt_q <= '0;
            else if (run_i && tick_i)   cnt_q <= at_last ? '0 : cnt_q + 1'b1;
         end
      end
   endgenerate

endmodule

// File: rtl/uart_tx_parity.sv
// Parity over the configured number of data bits only.
module uart_tx_parity #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned MIN_W  = 5,
   parameter int unsigned SEL_W  = 2
) (
   input  logic [DATA_W-1:0] data_i,
   input  logic [SEL_W-1:0]  len_sel_i,
   input  logic              odd_i,
   output logic              par_o
);

   logic [DATA_W-1:0] keep;

   generate
      for (genvar g = 0; g < int'(DATA_W); g++) begin : g_keep
         if (g < int'(MIN_W)) begin : g_always
            assign keep[g] = 1'b1;
         end else begin : g_sel
            assign keep[g] = (int'(len_sel_i) >= (g - int'(MIN_W) + 1));
         end
      end
   endgenerate

   assign par_o = (^(data_i & keep)) ^ odd_i;

endmodule

// File: rtl/uart_tx_sequencer.sv
// Frame state machine, shift register and captured line settings.
module uart_tx_sequencer
   import uart_tx_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned MIN_W  = 5,
   parameter int unsigned SEL_W  = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tx_en_i,
   input  logic              fifo_empty_i,
   input  logic [DATA_W-1:0] fifo_data_i,
   input  logic [SEL_W-1:0]  len_sel_i,
   input  frame_opts_t       opts_i,
   input  logic              par_bit_i,
   input  logic              bit_done_i,
   output logic              load_o,
   output logic              run_o,
   output logic              txd_o
);

   localparam int unsigned IDX_W = $clog2(DATA_W);
   localparam logic [IDX_W-1:0] BASE_IDX = IDX_W'(MIN_W - 1);

   tx_phase_e         phase_q;
   logic [DATA_W-1:0] shreg_q;
   logic [SEL_W-1:0]  len_q;
   frame_opts_t       opts_q;
   logic              par_q;
   logic [IDX_W-1:0]  idx_q;

   logic [IDX_W-1:0]  last_idx;
   logic              frame_end;

   assign last_idx  = BASE_IDX + IDX_W'(len_q);
   assign frame_end = (phase_q == PH_STOP) && bit_done_i &&
                      (!opts_q.stop2 || idx_q[0]);
   assign load_o    = ((phase_q == PH_IDLE) || frame_end) && tx_en_i && !fifo_empty_i;
   assign run_o     = (phase_q != PH_IDLE);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         phase_q <= PH_IDLE;
         shreg_q <= '0;
         len_q   <= '0;
         opts_q  <= '0;
         par_q   <= 1'b0;
         idx_q   <= '0;
      end else if (load_o) begin
         phase_q <= PH_START;
         shreg_q <= fifo_data_i;
         len_q   <= len_sel_i;
         opts_q  <= opts_i;
         par_q   <= par_bit_i;
         idx_q   <= '0;
      end else if (frame_end) begin
         phase_q <= PH_IDLE;
         idx_q   <= '0;
      end else if (bit_done_i) begin
         unique case (phase_q)
            PH_START: begin
               phase_q <= PH_DATA;
               idx_q   <= '0;
            end
            PH_DATA: begin
               shreg_q <= shreg_q >> 1;
               if (idx_q == last_idx) begin
                  idx_q   <= '0;
                  phase_q <= opts_q.par_en ? PH_PARITY : PH_STOP;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            PH_PARITY: begin
               phase_q <= PH_STOP;
               idx_q   <= '0;
            end
            PH_STOP: idx_q <= idx_q + 1'b1;
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   always_comb begin
      case (phase_q)
         PH_START:  txd_o = 1'b0;
         PH_DATA:   txd_o = shreg_q[0];
         PH_PARITY: txd_o = par_q;
         default:   txd_o = 1'b1;
      endcase
   end

endmodule

// File: rtl/uart_tx_engine.sv
module uart_tx_engine
   import uart_tx_pkg::*;
#(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned MIN_W      = 5,
   parameter int unsigned OVERSAMPLE = 16,
   localparam int unsigned SEL_W     = $clog2(DATA_W - MIN_W + 1)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick16_i,
   input  logic              tx_en_i,
   input  logic [SEL_W-1:0]  word_len_i,
   input  logic              parity_en_i,
   input  logic              parity_odd_i,
   input  logic              two_stop_i,
   input  logic              fifo_empty_i,
   input  logic [DATA_W-1:0] fifo_data_i,
   output logic              fifo_pop_o,
   output logic              txd_o,
   output logic              busy_o
);

   generate
      if (MIN_W < 1 || MIN_W >= DATA_W) begin : g_bad_width
         $error("MIN_W must be at least 1 and below DATA_W");
      end
      if ((2 ** SEL_W) != (DATA_W - MIN_W + 1)) begin : g_bad_range
         $error("word length range must be a power of two in size");
      end
      if (OVERSAMPLE < 2) begin : g_bad_os
         $error("OVERSAMPLE must be at least 2");
      end
   endgenerate

   frame_opts_t opts;
   logic        par_bit;
   logic        load;
   logic        run;
   logic        bit_done;

   assign opts = '{par_en: parity_en_i, par_odd: parity_odd_i, stop2: two_stop_i};

   uart_tx_parity #(
      .DATA_W (DATA_W),
      .MIN_W  (MIN_W),
      .SEL_W  (SEL_W)
   ) u_parity (
      .data_i    (fifo_data_i),
      .len_sel_i (word_len_i),
      .odd_i     (parity_odd_i),
      .par_o     (par_bit)
   );

   uart_tx_bit_timer #(
      .OVERSAMPLE (OVERSAMPLE)
   ) u_timer (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .restart_i  (load),
      .run_i      (run),
      .tick_i     (tick16_i),
      .bit_done_o (bit_done)
   );

   uart_tx_sequencer #(
      .DATA_W (DATA_W),
      .MIN_W  (MIN_W),
      .SEL_W  (SEL_W)
   ) u_seq (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .tx_en_i      (tx_en_i),
      .fifo_empty_i (fifo_empty_i),
      .fifo_data_i  (fifo_data_i),
      .len_sel_i    (word_len_i),
      .opts_i       (opts),
      .par_bit_i    (par_bit),
      .bit_done_i   (bit_done),
      .load_o       (load),
      .run_o        (run),
      .txd_o        (txd_o)
   );

   assign fifo_pop_o = load;
   assign busy_o     = run || !fifo_empty_i;

endmodule

// File: rtl/uart_tx_engine_chk.sv
module uart_tx_engine_chk (
   input logic clk_i,
   input logic rst_ni,
   input logic tick16_i,
   input logic tx_en_i,
   input logic fifo_empty_i,
   input logic fifo_pop_o,
   input logic txd_o,
   input logic busy_o
);

   // R1
   idle_line_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_o |-> txd_o);

   // R8
   busy_with_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !fifo_empty_i |-> busy_o);

   // R6
   pop_needs_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fifo_pop_o |-> (tx_en_i && !fifo_empty_i));

   // R6
   pop_single_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fifo_pop_o |=> !fifo_pop_o);

   // R6
   start_after_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fifo_pop_o |=> !txd_o);

   // R3
   line_moves_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(txd_o) |-> ($past(tick16_i) || $past(fifo_pop_o)));

endmodule

bind uart_tx_engine uart_tx_engine_chk u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .tick16_i     (tick16_i),
   .tx_en_i      (tx_en_i),
   .fifo_empty_i (fifo_empty_i),
   .fifo_pop_o   (fifo_pop_o),
   .txd_o        (txd_o),
   .busy_o       (busy_o)
);

// File: tb/uart_tx_engine_tb_top.sv
`timescale 1ns/1ps
module uart_tx_engine_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick16 = 1'b0;
   logic       tx_en = 1'b0;
   logic [1:0] word_len = 2'd3;
   logic       par_en = 1'b0;
   logic       par_odd = 1'b0;
   logic       two_stop = 1'b0;
   logic       fifo_empty;
   logic [7:0] fifo_data;
   logic       fifo_pop;
   logic       txd;
   logic       busy;

   always #2 clk = ~clk;

   // queue model
   logic [7:0]  qmem [16];
   int unsigned wr_ptr = 0;
   int unsigned rd_ptr = 0;
   int unsigned bad_pops = 0;
   assign fifo_empty = (wr_ptr == rd_ptr);
   assign fifo_data  = qmem[rd_ptr % 16];

   always @(posedge clk) begin
      if (fifo_pop) begin
         if (wr_ptr == rd_ptr) bad_pops <= bad_pops + 1;
         rd_ptr <= rd_ptr + 1;
      end
   end

   // tick generator and tick count
   int          tick_per = 1;
   int          tdiv = 0;
   int unsigned tick_total = 0;
   always @(negedge clk) begin
      if (tdiv + 1 >= tick_per) tdiv = 0;
      else                      tdiv = tdiv + 1;
      tick16 = (tdiv == 0);
   end
   always @(posedge clk) if (tick16) tick_total <= tick_total + 1;

   uart_tx_engine dut_i (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .tick16_i     (tick16),
      .tx_en_i      (tx_en),
      .word_len_i   (word_len),
      .parity_en_i  (par_en),
      .parity_odd_i (par_odd),
      .two_stop_i   (two_stop),
      .fifo_empty_i (fifo_empty),
      .fifo_data_i  (fifo_data),
      .fifo_pop_o   (fifo_pop),
      .txd_o        (txd),
      .busy_o       (busy)
   );

   int n_chk = 0;
   int n_bad = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic push(input logic [7:0] d);
      qmem[wr_ptr % 16] = d;
      wr_ptr = wr_ptr + 1;
   endtask

   task automatic set_cfg(input logic [1:0] wl, input logic pe, input logic po, input logic ts);
      word_len = wl; par_en = pe; par_odd = po; two_stop = ts;
   endtask

   function automatic logic [11:0] build_frame(input logic [7:0] d, input logic [1:0] wl,
                                                input logic pe, input logic po, input logic ts,
                                                output int nb);
      logic [11:0] f;
      int p;
      logic par;
      f = '1; p = 0; par = po;
      f[p] = 1'b0; p++;
      for (int i = 0; i < 5 + int'(wl); i++) begin
         f[p] = d[i]; par ^= d[i]; p++;
      end
      if (pe) begin f[p] = par; p++; end
      f[p] = 1'b1; p++;
      if (ts) begin f[p] = 1'b1; p++; end
      nb = p;
      return f;
   endfunction

   // Receives one frame; drop_at / chg_at are tick offsets (-1 = never)
   task automatic run_frame(input logic [7:0] d, input logic [1:0] wl, input logic pe,
                            input logic po, input logic ts, input int drop_at, input int chg_at,
                            input bit exp_next, input bit exp_busy_post, input string tag);
      logic [11:0] ef, s1, s8, s15, msk;
      int nb, guard, tgt, off;
      int unsigned base;
      bit changed;
      logic bpre, bpost, tpost;
      ef = build_frame(d, wl, pe, po, ts, nb);
      msk = (12'd1 << nb) - 12'd1;
      s1 = '0; s8 = '0; s15 = '0; changed = 0;
      guard = 0;
      while (txd === 1'b1 && guard < 20000) begin @(negedge clk); guard++; end
      if (guard >= 20000) begin
         check(0, tag, "no start bit seen", 0, 1);
         return;
      end
      base = tick_total;
      for (int b = 0; b <= nb; b++) begin
         for (int o = 0; o < 3; o++) begin
            if (b == nb && o > 1) break;
            if (b == nb) off = (o == 0) ? -1 : 0;
            else         off = (o == 0) ? 1 : ((o == 1) ? 8 : 15);
            tgt = 16 * b + off;
            guard = 0;
            while (int'(tick_total - base) < tgt && guard < 20000) begin
               @(negedge clk);
               guard++;
               if (drop_at >= 0 && int'(tick_total - base) >= drop_at) tx_en = 1'b0;
               if (chg_at >= 0 && !changed && int'(tick_total - base) >= chg_at) begin
                  changed = 1;
                  set_cfg(~word_len, ~par_en, ~par_odd, ~two_stop);
               end
            end
            if (b == nb) begin
               if (o == 0) bpre = busy;
               else begin bpost = busy; tpost = txd; end
            end else begin
               if (o == 0) s1[b] = txd;
               else if (o == 1) s8[b] = txd;
               else s15[b] = txd;
            end
         end
      end
      check((s8 & msk) == (ef & msk), tag, "frame bits (mid-bit)", s8 & msk, ef & msk);
      // R3: bit edges land exactly every 16 ticks
      check(((s1 & msk) == (ef & msk)) && ((s15 & msk) == (ef & msk)), "R3",
            "bit start/end samples", {s1 & msk, s15 & msk}, {ef & msk, ef & msk});
      check(bpre === 1'b1, "R8", "busy during last stop tick", bpre, 1);
      check(bpost === exp_busy_post, "R8", "busy after frame end", bpost, exp_busy_post);
      // R7: immediate restart, or idle line
      check(tpost === !exp_next, "R7", "line after last stop", tpost, !exp_next);
   endtask

   // stimulus vectors: {tick_per[15:13], two_stop[12], par_odd[11], par_en[10], word_len[9:8], data[7:0]}
   localparam logic [15:0] VECS [6] = '{
      16'h23A5,   // 8N1, tick every cycle                 R2
      16'h243C,   // 5 bits, even parity                   R2 R4
      16'h7DFF,   // 6 bits, odd parity, 2 stop, tick/3    R4 R5 R3
      16'h565A,   // 7 bits, even parity, 2 stop, tick/2   R4 R5
      16'h2F01,   // 8 bits, odd parity                    R4
      16'h8780    // 8 bits, even parity, tick/4           R3 R4
   };

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      bit saw_low, saw_idle;
      // R1 reset state
      repeat (4) @(negedge clk);
      check(txd === 1'b1 && busy === 1'b0 && fifo_pop === 1'b0, "R1", "outputs in reset",
            {txd, busy, fifo_pop}, 3'b100);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(txd === 1'b1 && busy === 1'b0 && fifo_pop === 1'b0, "R1", "outputs after reset",
            {txd, busy, fifo_pop}, 3'b100);

      // vector table: single frames under varied settings
      foreach (VECS[v]) begin
         tick_per = int'(VECS[v][15:13]);
         set_cfg(VECS[v][9:8], VECS[v][10], VECS[v][11], VECS[v][12]);
         push(VECS[v][7:0]);
         tx_en = 1'b1;
         run_frame(VECS[v][7:0], VECS[v][9:8], VECS[v][10], VECS[v][11], VECS[v][12],
                   -1, -1, 0, 0, "R2/R4/R5");
         check(wr_ptr == rd_ptr, "R6", "one pop per frame", rd_ptr, wr_ptr);
         repeat (5) @(negedge clk);
      end

      // R6 R8: disabled with queued data
      tick_per = 1;
      tx_en = 1'b0;
      set_cfg(2'd3, 1'b0, 1'b0, 1'b0);
      push(8'h96);
      saw_low = 0; saw_idle = 0;
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         if (txd !== 1'b1) saw_low = 1;
         if (busy !== 1'b1) saw_idle = 1;
      end
      check(!saw_low, "R6", "line stays high while disabled", saw_low, 0);
      check(!saw_idle, "R8", "busy with queued data while disabled", saw_idle, 0);
      check(wr_ptr - rd_ptr == 1, "R6", "no pop while disabled", wr_ptr - rd_ptr, 1);
      tx_en = 1'b1;
      run_frame(8'h96, 2'd3, 1'b0, 1'b0, 1'b0, -1, -1, 0, 0, "R6");

      // R7 back-to-back frames
      repeat (3) @(negedge clk);
      set_cfg(2'd2, 1'b1, 1'b0, 1'b0);
      push(8'h11); push(8'h22); push(8'h33);
      run_frame(8'h11, 2'd2, 1'b1, 1'b0, 1'b0, -1, -1, 1, 1, "R7");
      run_frame(8'h22, 2'd2, 1'b1, 1'b0, 1'b0, -1, -1, 1, 1, "R7");
      run_frame(8'h33, 2'd2, 1'b1, 1'b0, 1'b0, -1, -1, 0, 0, "R7");

      // R9 drop enable mid-frame
      repeat (3) @(negedge clk);
      set_cfg(2'd3, 1'b0, 1'b0, 1'b1);
      push(8'hC3); push(8'h5E);
      run_frame(8'hC3, 2'd3, 1'b0, 1'b0, 1'b1, 40, -1, 0, 1, "R9");
      saw_low = 0;
      for (int i = 0; i < 80; i++) begin
         @(negedge clk);
         if (txd !== 1'b1) saw_low = 1;
      end
      check(!saw_low, "R9", "no new frame after disable", saw_low, 0);
      check(wr_ptr - rd_ptr == 1, "R9", "second byte kept queued", wr_ptr - rd_ptr, 1);
      check(busy === 1'b1, "R8", "busy held by queued byte", busy, 1);
      tx_en = 1'b1;
      run_frame(8'h5E, 2'd3, 1'b0, 1'b0, 1'b1, -1, -1, 0, 0, "R9");

      // R10 settings flipped mid-frame
      repeat (3) @(negedge clk);
      set_cfg(2'd1, 1'b1, 1'b1, 1'b0);
      push(8'h2D);
      run_frame(8'h2D, 2'd1, 1'b1, 1'b1, 1'b0, -1, 20, 0, 0, "R10");
      set_cfg(2'd3, 1'b0, 1'b0, 1'b0);

      repeat (5) @(negedge clk);
      check(bad_pops == 0 && wr_ptr == rd_ptr, "R6", "pops match pushes",
            rd_ptr, wr_ptr);
      check(txd === 1'b1 && busy === 1'b0, "R1", "idle at end", {txd, busy}, 2'b10);
      summary();
      $finish;
   end

endmodule